// File: doc/BRIEF.md
# Multicycle Register-File Processor Core

This block is a small programmable processor built as a controller state machine driving a datapath. The datapath holds sixteen general registers, a program counter, an instruction register and a two-input arithmetic unit that raises a zero flag. Instructions and data share one memory, which sits outside the block. The memory answers reads combinationally in the same cycle, and it takes writes on the clock edge.

Every instruction is 16 bits wide. The opcode sits in bits 15:12 and the first register index (rn) in bits 11:8. Bits 7:4 hold the second register index (rm), or bits 7:0 hold an 8-bit field used as a direct address, an immediate value or a jump target. The controller walks FETCH, then DECODE, then one execute state per opcode, and returns to FETCH. The transitions are: FETCH to DECODE always. DECODE to LOAD_DIRECT (0000), STORE_DIRECT (0001), STORE_INDIRECT (0010), LOAD_IMMEDIATE (0011), ADD (0100), SUBTRACT (0101) or JUMP_ZERO (0110). DECODE returns to FETCH for any other opcode. Every execute state returns to FETCH.

The memory address comes from a three-way select: the program counter, the zero-extended 8-bit field, or register rn. The register write data comes from a two-way select: the arithmetic result or the memory read data.

Top module: `cpu_core`

## Requirements
- R1: While reset is high on a clock edge, the program counter, the instruction register and all sixteen registers become 0 and the controller enters FETCH. The first cycle after reset drives address 0 with the read strobe high.
- R2: In FETCH the block drives the program counter on the address port with the read strobe high. It latches the read word as the instruction and adds one to the program counter. DECODE, the next state, asserts neither strobe.
- R3: Opcode 0000 reads memory at the zero-extended bits 7:0 with the read strobe high and writes the word into register rn.
- R4: Opcode 0001 raises the write strobe with the address at the zero-extended bits 7:0 and the write data equal to register rn.
- R5: Opcode 0010 raises the write strobe with the address taken from the low bits of register rn and the write data equal to register rm.
- R6: Opcode 0011 writes bits 7:0, zero-extended to 16 bits, into register rn.
- R7: Opcode 0100 sets register rn to rn plus rm, modulo 2^16.
- R8: Opcode 0101 sets register rn to rn minus rm, modulo 2^16.
- R9: Opcode 0110 loads the program counter with the zero-extended bits 7:0 when register rn is zero. Otherwise the next fetch is from the following word.
- R10: Opcodes 0111 to 1111 change no register and no memory word, and the cycle after DECODE is FETCH.
- R11: The read and write strobes are never high together, and the write strobe is high only in the two store states.
- R12: Every defined opcode takes exactly three cycles: FETCH, DECODE and one execute state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, combinational |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |

## Verification
The bench builds the core with DATA_W of 16, ADDR_W of 8 and NREG of 16. With these values the 8-bit direct field spans the whole 256-word memory, so direct stores, indirect stores through a register and jump targets can reach any word. A program exercises every opcode. It includes a subtraction that wraps below zero, an immediate of 0xFF that tests zero extension, a taken jump, a jump that is not taken, two undefined opcodes and a second reset that must clear a register the first run had set.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_LDDIR,
        ST_STDIR,
        ST_STIND,
        ST_LDIMM,
        ST_ADD,
        ST_SUB,
        ST_JZ
    } state_t;

    localparam logic [3:0] OP_LDDIR = 4'h0;
    localparam logic [3:0] OP_STDIR = 4'h1;
    localparam logic [3:0] OP_STIND = 4'h2;
    localparam logic [3:0] OP_LDIMM = 4'h3;
    localparam logic [3:0] OP_ADD   = 4'h4;
    localparam logic [3:0] OP_SUB   = 4'h5;
    localparam logic [3:0] OP_JZ    = 4'h6;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_PASSA,
        ALU_PASSB
    } alu_op_t;

    typedef enum logic [1:0] {
        AS_PC,
        AS_DIR,
        AS_REG
    } addr_sel_t;

    typedef struct packed {
        logic      ir_ld;
        logic      pc_inc;
        logic      pc_ld;
        logic      rf_we;
        logic      wsel_mem;
        logic      rd1_en;
        logic      rd2_en;
        logic      rd2_sel_rn;
        logic      b_imm;
        alu_op_t   alu_op;
        addr_sel_t addr_sel;
        logic      mem_re;
        logic      mem_we;
    } ctrl_t;

endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd1_en,
    input  logic [IDX_W-1:0]  rd1_addr,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              rd2_en,
    input  logic [IDX_W-1:0]  rd2_addr,
    output logic [DATA_W-1:0] rd2_data
);

    logic [DATA_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd1_data = rd1_en ? regs[rd1_addr] : '0;
    assign rd2_data = rd2_en ? regs[rd2_addr] : '0;

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              zero
);

    always_comb begin
        unique case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_PASSA: y = a;
            ALU_PASSB: y = b;
            default:   y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] opcode,
    input  logic       alu_zero,
    output state_t     state,
    output ctrl_t      ctl
);

    state_t state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = ST_FETCH;
        unique case (state)
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (opcode)
                    OP_LDDIR: state_nx = ST_LDDIR;
                    OP_STDIR: state_nx = ST_STDIR;
                    OP_STIND: state_nx = ST_STIND;
                    OP_LDIMM: state_nx = ST_LDIMM;
                    OP_ADD:   state_nx = ST_ADD;
                    OP_SUB:   state_nx = ST_SUB;
                    OP_JZ:    state_nx = ST_JZ;
                    default:  state_nx = ST_FETCH;
                endcase
            end
            default:   state_nx = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        ctl          = '0;
        ctl.alu_op   = ALU_PASSA;
        ctl.addr_sel = AS_PC;
        unique case (state)
            ST_FETCH: begin
                ctl.addr_sel = AS_PC;
                ctl.mem_re   = 1'b1;
                ctl.ir_ld    = 1'b1;
                ctl.pc_inc   = 1'b1;
            end
            ST_DECODE: begin
            end
            ST_LDDIR: begin
                ctl.addr_sel = AS_DIR;
                ctl.mem_re   = 1'b1;
                ctl.rf_we    = 1'b1;
                ctl.wsel_mem = 1'b1;
            end
            ST_STDIR: begin
                ctl.addr_sel   = AS_DIR;
                ctl.rd2_en     = 1'b1;
                ctl.rd2_sel_rn = 1'b1;
                ctl.mem_we     = 1'b1;
            end
            ST_STIND: begin
                ctl.addr_sel = AS_REG;
                ctl.rd1_en   = 1'b1;
                ctl.rd2_en   = 1'b1;
                ctl.mem_we   = 1'b1;
            end
            ST_LDIMM: begin
                ctl.b_imm  = 1'b1;
                ctl.alu_op = ALU_PASSB;
                ctl.rf_we  = 1'b1;
            end
            ST_ADD: begin
                ctl.rd1_en = 1'b1;
                ctl.rd2_en = 1'b1;
                ctl.alu_op = ALU_ADD;
                ctl.rf_we  = 1'b1;
            end
            ST_SUB: begin
                ctl.rd1_en = 1'b1;
                ctl.rd2_en = 1'b1;
                ctl.alu_op = ALU_SUB;
                ctl.rf_we  = 1'b1;
            end
            ST_JZ: begin
                ctl.rd1_en = 1'b1;
                ctl.alu_op = ALU_PASSA;
                ctl.pc_ld  = alu_zero;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int NREG   = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic              mem_we
);

    localparam int IDX_W   = $clog2(NREG);
    localparam int FLD_W   = 8;
    localparam int OP_LSB  = DATA_W - 4;
    localparam int RN_LSB  = DATA_W - 8;
    localparam int RM_LSB  = DATA_W - 12;

    state_t            state;
    ctrl_t             ctl;
    logic [ADDR_W-1:0] pc;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] rd1_data;
    logic [DATA_W-1:0] rd2_data;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] alu_y;
    logic              alu_zero;
    logic [DATA_W-1:0] rf_wdata;

    logic [3:0]        opcode;
    logic [IDX_W-1:0]  rn;
    logic [IDX_W-1:0]  rm;
    logic [FLD_W-1:0]  field;

    assign opcode = ir[OP_LSB +: 4];
    assign rn     = ir[RN_LSB +: IDX_W];
    assign rm     = ir[RM_LSB +: IDX_W];
    assign field  = ir[FLD_W-1:0];

    cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .alu_zero (alu_zero),
        .state    (state),
        .ctl      (ctl)
    );

    cpu_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) u_rf (
        .clk      (clk),
        .rst      (rst),
        .we       (ctl.rf_we),
        .waddr    (rn),
        .wdata    (rf_wdata),
        .rd1_en   (ctl.rd1_en),
        .rd1_addr (rn),
        .rd1_data (rd1_data),
        .rd2_en   (ctl.rd2_en),
        .rd2_addr (ctl.rd2_sel_rn ? rn : rm),
        .rd2_data (rd2_data)
    );

    assign alu_b = ctl.b_imm ? DATA_W'(field) : rd2_data;

    cpu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op   (ctl.alu_op),
        .a    (rd1_data),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign rf_wdata = ctl.wsel_mem ? mem_rdata : alu_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ir <= '0;
        end else begin
            if (ctl.ir_ld) begin
                ir <= mem_rdata;
            end
            if (ctl.pc_ld) begin
                pc <= ADDR_W'(field);
            end else if (ctl.pc_inc) begin
                pc <= pc + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (ctl.addr_sel)
            AS_PC:   mem_addr = pc;
            AS_DIR:  mem_addr = ADDR_W'(field);
            AS_REG:  mem_addr = ADDR_W'(rd1_data);
            default: mem_addr = pc;
        endcase
    end

    assign mem_wdata = rd2_data;
    assign mem_re    = ctl.mem_re;
    assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
    import cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_re,
    input logic              mem_we,
    input state_t            state,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] ir,
    input logic              alu_zero
);

    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_re && mem_addr == '0)); // R1

    AST_PC_INC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (pc == $past(pc) + 1'b1)); // R2

    AST_DECODE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (!mem_re && !mem_we)); // R2

    AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JZ && alu_zero) |=> (pc == ADDR_W'($past(ir[7:0])))); // R9

    AST_JZ_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JZ && !alu_zero) |=> $stable(pc)); // R9

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R11

    AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (state == ST_STDIR || state == ST_STIND)); // R11

    AST_EXEC_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FETCH && state != ST_DECODE) |=> (state == ST_FETCH)); // R12

endmodule

bind cpu_core cpu_core_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .state    (state),
    .pc       (pc),
    .ir       (ir),
    .alu_zero (alu_zero)
);

// File: tb/cpu_core_bench.sv
module cpu_core_bench;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int NREG   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_re;
    logic              mem_we;

    logic [15:0] mem [256];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    cpu_core #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .NREG   (NREG)
    ) u_cpu_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_re    (mem_re),
        .mem_we    (mem_we)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    int          m_phase = 0;
    logic [7:0]  m_pc    = '0;
    logic [15:0] m_ir    = '0;
    logic [15:0] m_rf [16];

    function automatic string op_req(input logic [3:0] op);
        case (op)
            4'h0:    return "R3";
            4'h1:    return "R4";
            4'h2:    return "R5";
            4'h3:    return "R6";
            4'h4:    return "R7";
            4'h5:    return "R8";
            4'h6:    return "R9";
            default: return "R10";
        endcase
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            m_phase = 0;
            m_pc    = '0;
            m_ir    = '0;
            for (int i = 0; i < 16; i++) m_rf[i] = '0;
        end else begin
            logic [3:0] op;
            logic [3:0] rn;
            logic [3:0] rm;
            logic [7:0] fld;
            op  = m_ir[15:12];
            rn  = m_ir[11:8];
            rm  = m_ir[7:4];
            fld = m_ir[7:0];
            check("R11", {31'd0, mem_re & mem_we}, 32'd0);
            case (m_phase)
                0: begin
                    check("R2/R12 fetch re", {31'd0, mem_re}, 32'd1);
                    check("R2/R12 fetch we", {31'd0, mem_we}, 32'd0);
                    check("R2/R12 fetch addr", {24'd0, mem_addr}, {24'd0, m_pc});
                    m_ir    = mem[m_pc];
                    m_pc    = m_pc + 8'd1;
                    m_phase = 1;
                end
                1: begin
                    check("R2 decode re", {31'd0, mem_re}, 32'd0);
                    check("R2 decode we", {31'd0, mem_we}, 32'd0);
                    m_phase = (op <= 4'h6) ? 2 : 0;
                end
                default: begin
                    check({op_req(op), " exec re"}, {31'd0, mem_re}, {31'd0, op == 4'h0});
                    check({op_req(op), " exec we"}, {31'd0, mem_we},
                          {31'd0, op == 4'h1 || op == 4'h2});
                    case (op)
                        4'h0: begin
                            check("R3 addr", {24'd0, mem_addr}, {24'd0, fld});
                            m_rf[rn] = mem[fld];
                        end
                        4'h1: begin
                            check("R4 addr", {24'd0, mem_addr}, {24'd0, fld});
                            check("R4 data", {16'd0, mem_wdata}, {16'd0, m_rf[rn]});
                        end
                        4'h2: begin
                            check("R5 addr", {24'd0, mem_addr}, {24'd0, m_rf[rn][7:0]});
                            check("R5 data", {16'd0, mem_wdata}, {16'd0, m_rf[rm]});
                        end
                        4'h3: m_rf[rn] = {8'd0, fld};
                        4'h4: m_rf[rn] = m_rf[rn] + m_rf[rm];
                        4'h5: m_rf[rn] = m_rf[rn] - m_rf[rm];
                        4'h6: if (m_rf[rn] == 16'd0) m_pc = fld;
                        default: ;
                    endcase
                    m_phase = 0;
                end
            endcase
        end
        if (cyc > 5000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h00] = 16'h3105; // r1 = 5
        mem[8'h01] = 16'h3203; // r2 = 3
        mem[8'h02] = 16'h4120; // r1 = r1 + r2
        mem[8'h03] = 16'h1180; // [80] = r1
        mem[8'h04] = 16'h5210; // r2 = r2 - r1 (wraps)
        mem[8'h05] = 16'h1281; // [81] = r2
        mem[8'h06] = 16'h0390; // r3 = [90]
        mem[8'h07] = 16'h34A0; // r4 = A0
        mem[8'h08] = 16'h2430; // [r4] = r3
        mem[8'h09] = 16'h7120; // undefined
        mem[8'h0A] = 16'hF1FF; // undefined
        mem[8'h0B] = 16'h6510; // r5 zero: jump to 10
        mem[8'h0C] = 16'h3601; // skipped
        mem[8'h10] = 16'h6114; // r1 nonzero: fall through
        mem[8'h11] = 16'h1682; // [82] = r6
        mem[8'h12] = 16'h1183; // [83] = r1
        mem[8'h13] = 16'h3EFF; // r14 = FF
        mem[8'h14] = 16'h1E84; // [84] = r14
        mem[8'h15] = 16'h3F77; // r15 = 77
        mem[8'h16] = 16'h6516; // park
        mem[8'h90] = 16'h1234;

        rst = 1'b1;
        run(3);
        #1 rst = 1'b0;
        @(negedge clk); #0.5;
        check("R1 first addr", {24'd0, mem_addr}, 32'd0);
        check("R1 first re", {31'd0, mem_re}, 32'd1);
        run(90);
        #1;
        check("R7 sum", {16'd0, mem[8'h80]}, 32'h0008);
        check("R8 wrap", {16'd0, mem[8'h81]}, 32'hFFFB);
        check("R3/R5 copy", {16'd0, mem[8'hA0]}, 32'h1234);
        check("R9 skip", {16'd0, mem[8'h82]}, 32'h0000);
        check("R10 r1 kept", {16'd0, mem[8'h83]}, 32'h0008);
        check("R6 zext", {16'd0, mem[8'h84]}, 32'h00FF);
        check("R10 mem kept", {16'd0, mem[8'h20]}, 32'h0000);

        // second run after reset: r15 must be cleared
        @(posedge clk); #1 rst = 1'b1;
        mem[8'h00] = 16'h1F85; // [85] = r15
        mem[8'h01] = 16'h6501; // park
        mem[8'h85] = 16'hBEEF;
        run(2);
        #1 rst = 1'b0;
        @(negedge clk); #0.5;
        check("R1 restart addr", {24'd0, mem_addr}, 32'd0);
        run(20);
        #1;
        check("R1 regs cleared", {16'd0, mem[8'h85]}, 32'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule